// File: doc/BRIEF.md
# Short-Descriptor First-Level Table Address Generator

This block keeps the translation control register and the two translation base registers of a 32-bit memory management unit that walks short-descriptor tables. Given a virtual address, it works out which base register covers that address. It then forms the word-aligned address of the first-level descriptor to fetch. If walks are disabled for the chosen base, it reports a section translation fault instead.

Writes to the control register are masked according to three static feature inputs: long-descriptor support, security extensions and v8 mode. The masks that split the address space and align base 0 are recomputed on every control write. A lookup request is answered with a one-cycle valid pulse on the next clock. The descriptor fetch, the second-level walk and the permission checks belong to the surrounding walker.

Top module: `l1_walk_addr_gen`

## Requirements
- R1: After synchronous reset, the control register and both base registers read zero and `rsp_valid` is low.
- R2: With `cfg_v8` high, a control write stores the whole 32-bit data word unchanged.
- R3: With `cfg_v8` low, `cfg_long_desc` high and data bit 31 (extended-address enable) set, a control write clears bits [21:19], [15:14] and [6:3] and keeps every other bit.
- R4: With `cfg_v8` low and the R3 case not applying, a control write keeps only bits [2:0] (table split N), bit 4 (base 0 walk disable) and bit 5 (base 1 walk disable) when `cfg_sec_ext` is high, and only bits [2:0] when it is low.
- R5: Each base register stores the full data word when its own write enable is high, and holds its value otherwise.
- R6: A lookup selects base 1 (`rsp_base_sel`=1) when the address ANDed with the complement of (0xFFFFFFFF >> N) is nonzero, and base 0 otherwise; with N=0, base 0 is always selected.
- R7: On a fault-free lookup, `rsp_addr` equals (base1 AND 0xFFFFC000) or (base0 AND NOT(0x3FFF >> N)), ORed with (address >> 18) AND 0x3FFC, and `rsp_status` is 0.
- R8: When base 1 is selected with control bit 5 set, or base 0 is selected with control bit 4 set, the response has `rsp_fault`=1, `rsp_status`=5, `rsp_addr`=0 and `rsp_domain`=0.
- R9: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. The lookup uses the register values held before any write on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_long_desc | input | 1 | Long-descriptor format supported |
| cfg_sec_ext | input | 1 | Security extensions present |
| cfg_v8 | input | 1 | v8 mode: control writes are not masked |
| ctl_wr_en | input | 1 | Write the control register |
| base0_wr_en | input | 1 | Write base register 0 |
| base1_wr_en | input | 1 | Write base register 1 |
| wr_data | input | 32 | Write data shared by all three registers |
| ctl_q | output | 32 | Control register contents |
| base0_q | output | 32 | Base register 0 contents |
| base1_q | output | 32 | Base register 1 contents |
| req_valid | input | 1 | Lookup request |
| req_va | input | 32 | Virtual address to look up |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_addr | output | 32 | First-level descriptor address, zero on fault |
| rsp_fault | output | 1 | Walk disabled for the selected base |
| rsp_status | output | 4 | Fault status: 5 on fault, 0 otherwise |
| rsp_domain | output | 4 | Domain reported with the response, zero |
| rsp_base_sel | output | 1 | Base register used: 0 or 1 |

## Verification
A register write is driven before one rising edge, and the register readback is sampled on the falling edge that follows, one cycle later. A lookup is also driven before one rising edge, and its response is sampled on the next falling edge. `rsp_valid` is checked again one cycle after that, to confirm it has dropped. The bench keeps its own model of the three registers and updates it only after each check. A lookup issued together with a control write is therefore compared against the values from before the write.

// File: rtl/l1ag_pkg.sv
package l1ag_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned SPLIT_W   = 3;
  localparam int unsigned STATUS_W  = 4;
  localparam int unsigned DOM_W     = 4;
  localparam int unsigned NUM_BASE  = 2;
  localparam int unsigned WD0_BIT   = 4;
  localparam int unsigned WD1_BIT   = 5;
  localparam int unsigned XADDR_BIT = 31;
  localparam int unsigned TBL_ALIGN = 14;
  localparam int unsigned IDX_SHIFT = 18;

  localparam logic [STATUS_W-1:0] ST_OK        = '0;
  localparam logic [STATUS_W-1:0] ST_SECT_XLAT = STATUS_W'(5);

  localparam logic [WORD_W-1:0] ALL_ONES  = '1;
  localparam logic [WORD_W-1:0] LOW_ALIGN = WORD_W'((64'd1 << TBL_ALIGN) - 64'd1);
  localparam logic [WORD_W-1:0] IDX_MASK  = LOW_ALIGN & ~WORD_W'(3);
  localparam logic [WORD_W-1:0] SPLIT_KEEP = WORD_W'((64'd1 << SPLIT_W) - 64'd1);

  typedef struct packed {
    logic                fault;
    logic                sel1;
    logic [WORD_W-1:0]   addr;
  } lk_res_t;
endpackage

// File: rtl/l1ag_ctl_reg.sv
module l1ag_ctl_reg
  import l1ag_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              cfg_long_desc,
  input  logic              cfg_sec_ext,
  input  logic              cfg_v8,
  output logic [WORD_W-1:0] ctl_q,
  output logic [WORD_W-1:0] hi_mask_q,
  output logic [WORD_W-1:0] b0_mask_q
);
  localparam logic [WORD_W-1:0] LONG_CLR =
      WORD_W'(32'h7 << 19) | WORD_W'(32'h3 << 14) | WORD_W'(32'hF << 3);
  localparam logic [WORD_W-1:0] SEC_KEEP =
      SPLIT_KEEP | (WORD_W'(1) << WD0_BIT) | (WORD_W'(1) << WD1_BIT);

  logic [WORD_W-1:0]  masked;
  logic [SPLIT_W-1:0] split_n;

  always_comb begin
    split_n = wr_data[SPLIT_W-1:0];
    if (cfg_v8)
      masked = wr_data;
    else if (cfg_long_desc && wr_data[XADDR_BIT])
      masked = wr_data & ~LONG_CLR;
    else if (cfg_sec_ext)
      masked = wr_data & SEC_KEEP;
    else
      masked = wr_data & SPLIT_KEEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '0;
      hi_mask_q <= '0;
      b0_mask_q <= ~LOW_ALIGN;
    end else if (wr_en) begin
      ctl_q     <= masked;
      hi_mask_q <= ~(ALL_ONES >> split_n);
      b0_mask_q <= ~(LOW_ALIGN >> split_n);
    end
  end
endmodule

// File: rtl/l1ag_base_bank.sv
module l1ag_base_bank
  import l1ag_pkg::*;
#(
  parameter int unsigned N_REGS = NUM_BASE
)(
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_REGS-1:0]             wr_en,
  input  logic [WORD_W-1:0]             wr_data,
  output logic [N_REGS-1:0][WORD_W-1:0] base_q
);
  for (genvar g = 0; g < N_REGS; g++) begin : g_base
    always_ff @(posedge clk) begin
      if (rst)
        base_q[g] <= '0;
      else if (wr_en[g])
        base_q[g] <= wr_data;
    end
  end
endmodule

// File: rtl/l1ag_lookup.sv
module l1ag_lookup
  import l1ag_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [WORD_W-1:0]   req_va,
  input  logic [WORD_W-1:0]   ctl,
  input  logic [WORD_W-1:0]   hi_mask,
  input  logic [WORD_W-1:0]   b0_mask,
  input  logic [WORD_W-1:0]   base0,
  input  logic [WORD_W-1:0]   base1,
  output logic                rsp_valid,
  output logic [WORD_W-1:0]   rsp_addr,
  output logic                rsp_fault,
  output logic [STATUS_W-1:0] rsp_status,
  output logic                rsp_base_sel
);
  lk_res_t           res;
  logic [WORD_W-1:0] tbl_base;

  always_comb begin
    res.sel1  = |(req_va & hi_mask);
    tbl_base  = res.sel1 ? (base1 & ~LOW_ALIGN) : (base0 & b0_mask);
    res.fault = res.sel1 ? ctl[WD1_BIT] : ctl[WD0_BIT];
    res.addr  = res.fault ? '0 : (tbl_base | ((req_va >> IDX_SHIFT) & IDX_MASK));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_addr     <= '0;
      rsp_fault    <= 1'b0;
      rsp_status   <= ST_OK;
      rsp_base_sel <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_addr     <= res.addr;
        rsp_fault    <= res.fault;
        rsp_status   <= res.fault ? ST_SECT_XLAT : ST_OK;
        rsp_base_sel <= res.sel1;
      end
    end
  end
endmodule

// File: rtl/l1_walk_addr_gen.sv
module l1_walk_addr_gen
  import l1ag_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_long_desc,
  input  logic                cfg_sec_ext,
  input  logic                cfg_v8,
  input  logic                ctl_wr_en,
  input  logic                base0_wr_en,
  input  logic                base1_wr_en,
  input  logic [WORD_W-1:0]   wr_data,
  output logic [WORD_W-1:0]   ctl_q,
  output logic [WORD_W-1:0]   base0_q,
  output logic [WORD_W-1:0]   base1_q,
  input  logic                req_valid,
  input  logic [WORD_W-1:0]   req_va,
  output logic                rsp_valid,
  output logic [WORD_W-1:0]   rsp_addr,
  output logic                rsp_fault,
  output logic [STATUS_W-1:0] rsp_status,
  output logic [DOM_W-1:0]    rsp_domain,
  output logic                rsp_base_sel
);
  logic [WORD_W-1:0]                 hi_mask;
  logic [WORD_W-1:0]                 b0_mask;
  logic [NUM_BASE-1:0][WORD_W-1:0]   bases;

  l1ag_ctl_reg i_ctl (
    .clk(clk), .rst(rst), .wr_en(ctl_wr_en), .wr_data(wr_data),
    .cfg_long_desc(cfg_long_desc), .cfg_sec_ext(cfg_sec_ext), .cfg_v8(cfg_v8),
    .ctl_q(ctl_q), .hi_mask_q(hi_mask), .b0_mask_q(b0_mask)
  );

  l1ag_base_bank #(.N_REGS(NUM_BASE)) i_bases (
    .clk(clk), .rst(rst), .wr_en({base1_wr_en, base0_wr_en}),
    .wr_data(wr_data), .base_q(bases)
  );

  assign base0_q = bases[0];
  assign base1_q = bases[1];

  l1ag_lookup i_lookup (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
    .ctl(ctl_q), .hi_mask(hi_mask), .b0_mask(b0_mask),
    .base0(bases[0]), .base1(bases[1]),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
    .rsp_status(rsp_status), .rsp_base_sel(rsp_base_sel)
  );

  // No descriptor is read here, so no domain is known yet.
  assign rsp_domain = '0;
endmodule

// File: rtl/l1ag_chk.sv
module l1ag_chk
  import l1ag_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                cfg_long_desc,
  input logic                cfg_sec_ext,
  input logic                cfg_v8,
  input logic                ctl_wr_en,
  input logic                base0_wr_en,
  input logic [WORD_W-1:0]   wr_data,
  input logic [WORD_W-1:0]   ctl_q,
  input logic [WORD_W-1:0]   base0_q,
  input logic                req_valid,
  input logic                rsp_valid,
  input logic [WORD_W-1:0]   rsp_addr,
  input logic                rsp_fault,
  input logic [STATUS_W-1:0] rsp_status,
  input logic [DOM_W-1:0]    rsp_domain
);
  // R2
  v8_store_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_wr_en && cfg_v8 |=> ctl_q == $past(wr_data));

  // R4
  short_keep_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_wr_en && !cfg_v8 && !(cfg_long_desc && wr_data[XADDR_BIT]) |=>
      ctl_q[WORD_W-1:6] == '0 && ctl_q[3] == 1'b0);

  // R4
  nosec_keep_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_wr_en && !cfg_v8 && !cfg_sec_ext && !(cfg_long_desc && wr_data[XADDR_BIT]) |=>
      ctl_q[WORD_W-1:SPLIT_W] == '0);

  // R5
  base_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !base0_wr_en |=> $stable(base0_q));

  // R8
  fault_resp_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> rsp_status == ST_SECT_XLAT && rsp_addr == '0 && rsp_domain == '0);

  // R7
  ok_resp_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_fault |-> rsp_status == ST_OK && rsp_addr[1:0] == 2'b00);

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R9
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
endmodule

bind l1_walk_addr_gen l1ag_chk i_l1ag_chk (
  .clk(clk), .rst(rst), .cfg_long_desc(cfg_long_desc), .cfg_sec_ext(cfg_sec_ext),
  .cfg_v8(cfg_v8), .ctl_wr_en(ctl_wr_en), .base0_wr_en(base0_wr_en),
  .wr_data(wr_data), .ctl_q(ctl_q), .base0_q(base0_q), .req_valid(req_valid),
  .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
  .rsp_status(rsp_status), .rsp_domain(rsp_domain)
);

// File: tb/test_l1_walk_addr_gen.sv
module test_l1_walk_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_long_desc = 1'b0, cfg_sec_ext = 1'b0, cfg_v8 = 1'b0;
  logic        ctl_wr_en = 1'b0, base0_wr_en = 1'b0, base1_wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] ctl_q, base0_q, base1_q;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic        rsp_valid, rsp_fault, rsp_base_sel;
  logic [31:0] rsp_addr;
  logic [3:0]  rsp_status, rsp_domain;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [31:0] m_ctl = '0, m_b0 = '0, m_b1 = '0;

  always #10 clk = ~clk;

  l1_walk_addr_gen i_l1_walk_addr_gen (
    .clk(clk), .rst(rst), .cfg_long_desc(cfg_long_desc), .cfg_sec_ext(cfg_sec_ext),
    .cfg_v8(cfg_v8), .ctl_wr_en(ctl_wr_en), .base0_wr_en(base0_wr_en),
    .base1_wr_en(base1_wr_en), .wr_data(wr_data), .ctl_q(ctl_q), .base0_q(base0_q),
    .base1_q(base1_q), .req_valid(req_valid), .req_va(req_va), .rsp_valid(rsp_valid),
    .rsp_addr(rsp_addr), .rsp_fault(rsp_fault), .rsp_status(rsp_status),
    .rsp_domain(rsp_domain), .rsp_base_sel(rsp_base_sel)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mask_ctl(logic [31:0] d, logic lng, logic sec, logic v8);
    if (v8) return d;
    if (lng && d[31]) return d & ~32'h0038_C078;
    if (sec) return d & 32'h37;
    return d & 32'h7;
  endfunction

  function automatic logic exp_sel(logic [31:0] va, logic [31:0] c);
    return |(va & ~(32'hFFFF_FFFF >> c[2:0]));
  endfunction

  function automatic logic exp_fault(logic [31:0] va, logic [31:0] c);
    return exp_sel(va, c) ? c[5] : c[4];
  endfunction

  function automatic logic [31:0] exp_addr(logic [31:0] va, logic [31:0] c,
                                           logic [31:0] b0, logic [31:0] b1);
    logic [31:0] tb;
    if (exp_fault(va, c)) return '0;
    tb = exp_sel(va, c) ? (b1 & 32'hFFFF_C000) : (b0 & ~(32'h3FFF >> c[2:0]));
    return tb | ((va >> 18) & 32'h3FFC);
  endfunction

  task automatic wr_ctl(logic [31:0] d, logic lng, logic sec, logic v8, string tag);
    cfg_long_desc = lng; cfg_sec_ext = sec; cfg_v8 = v8;
    wr_data = d; ctl_wr_en = 1'b1;
    @(negedge clk);
    ctl_wr_en = 1'b0;
    m_ctl = mask_ctl(d, lng, sec, v8);
    chk(tag, ctl_q, m_ctl);
  endtask

  task automatic wr_base(bit which, logic [31:0] d);
    wr_data = d;
    if (which) base1_wr_en = 1'b1; else base0_wr_en = 1'b1;
    @(negedge clk);
    base0_wr_en = 1'b0; base1_wr_en = 1'b0;
    if (which) m_b1 = d; else m_b0 = d;
    chk("R5 written base", which ? base1_q : base0_q, d);
    chk("R5 other base holds", which ? base0_q : base1_q, which ? m_b0 : m_b1);
  endtask

  task automatic check_rsp(logic [31:0] va, logic [31:0] c, logic [31:0] b0, logic [31:0] b1);
    logic f;
    f = exp_fault(va, c);
    chk("R9 rsp_valid pulse", {31'd0, rsp_valid}, 32'd1);
    chk("R6 base select", {31'd0, rsp_base_sel}, {31'd0, exp_sel(va, c)});
    chk("R8 fault flag", {31'd0, rsp_fault}, {31'd0, f});
    chk(f ? "R8 fault status" : "R7 ok status", {28'd0, rsp_status}, f ? 32'd5 : 32'd0);
    chk(f ? "R8 fault addr" : "R7 descriptor addr", rsp_addr, exp_addr(va, c, b0, b1));
    chk("R8 domain", {28'd0, rsp_domain}, 32'd0);
  endtask

  task automatic lookup(logic [31:0] va);
    req_va = va; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(va, m_ctl, m_b0, m_b1);
    @(negedge clk);
    chk("R9 rsp_valid drops", {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    int seed;
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ctl reset", ctl_q, 32'd0);
    chk("R1 base0 reset", base0_q, 32'd0);
    chk("R1 base1 reset", base1_q, 32'd0);
    chk("R1 rsp_valid reset", {31'd0, rsp_valid}, 32'd0);

    wr_ctl(32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, "R2 v8 unmasked");
    chk("R2 v8 all ones", ctl_q, 32'hFFFF_FFFF);
    wr_ctl(32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, "R3 long clear");
    chk("R3 long clear value", ctl_q, 32'hFFC7_3F87);
    wr_ctl(32'h7FFF_FFFF, 1'b1, 1'b1, 1'b0, "R4 sec keep");
    chk("R4 sec keep value", ctl_q, 32'h0000_0037);
    wr_ctl(32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, "R4 nosec keep");
    chk("R4 nosec keep value", ctl_q, 32'h0000_0007);

    wr_base(1'b0, 32'h1234_5678);
    wr_base(1'b1, 32'h8765_4321);

    // R6: N=0 always uses base 0
    wr_ctl(32'h0, 1'b0, 1'b1, 1'b0, "R4 N=0");
    lookup(32'hFFFF_FFFF);
    chk("R6 N=0 picks base0", {31'd0, rsp_base_sel}, 32'd0);
    // R6/R7: N=2 splits at 1 GiB
    wr_ctl(32'h2, 1'b0, 1'b1, 1'b0, "R4 N=2");
    lookup(32'h4000_0000);
    lookup(32'h3FFF_FFFF);
    // R8: walk disables
    wr_ctl(32'h22, 1'b0, 1'b1, 1'b0, "R4 PD1");
    lookup(32'hC000_0000);
    lookup(32'h0010_0000);
    wr_ctl(32'h12, 1'b0, 1'b1, 1'b0, "R4 PD0");
    lookup(32'h0010_0000);
    lookup(32'hC000_0000);

    // R9: lookup together with a control write sees the old register value
    begin
      logic [31:0] old_c;
      old_c = m_ctl;
      cfg_v8 = 1'b0; cfg_long_desc = 1'b0; cfg_sec_ext = 1'b1;
      wr_data = 32'h0000_0030; ctl_wr_en = 1'b1;
      req_va = 32'h0010_0000; req_valid = 1'b1;
      @(negedge clk);
      ctl_wr_en = 1'b0; req_valid = 1'b0;
      m_ctl = 32'h30;
      check_rsp(32'h0010_0000, old_c, m_b0, m_b1);
      chk("R9 same-edge write lands", ctl_q, 32'h30);
      @(negedge clk);
    end

    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom_range(0, 5));
      case (op)
        0, 1: wr_ctl($urandom(), 1'($urandom()), 1'($urandom()), 1'($urandom_range(0, 3) == 0), "R2-mix ctl write");
        2: wr_base(1'($urandom()), $urandom());
        default: lookup($urandom());
      endcase
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule